// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Level Flags

A single-clock first-in first-out buffer whose read-side timing is chosen at reset. In standard timing, the data output changes only when a read is requested. The ready-out pin then reports whether any word is stored, and the ready-in pin reports whether a write would fit. In fall-through timing, the oldest stored word moves into an output register on its own. The ready-out pin then means "the word on `dout` is valid", and a read consumes that word. The word in the output register counts toward occupancy. Two active-low level flags report a nearly empty and a nearly full buffer. Their thresholds sit in two registers that can be loaded in parallel at any time outside reset.

A phase state machine sequences start-up. **ST_RESET** holds while `rst_n` is low. Its transition *release* goes to **ST_WAKE** on the first clock edge with `rst_n` high. The transition *arm* goes to **ST_RUN** on the next edge, and the machine stays in **ST_RUN** until `rst_n` drops, which is the transition *abort* from any state back to **ST_RESET**. A second state machine tracks the output register. **OS_EMPTY** takes the transition *present* to **OS_HELD** when a word is loaded in fall-through timing. **OS_HELD** takes the transition *drain* back to **OS_EMPTY** when a read consumes the word and nothing follows it. **OS_HELD** stays in place on a *refill*, a read that loads the next word in the same edge.

Top module: `dual_mode_fifo`

## Requirements
- R1: On every clock edge that samples `rst_n` low, the flags become `in_rdy`=0, `out_rdy`=0, `ae_n`=0 and `af_n`=1, `dout` becomes 0, both thresholds return to 8 and the buffer empties.
- R2: After `rst_n` is sampled high, `in_rdy` stays 0 after the first edge and becomes 1 after the second edge. Until then, writes and reads are not accepted.
- R3: The timing mode is the value of `fwft_sel` on the last edge that samples `rst_n` low: 1 selects fall-through and 0 selects standard. It does not change until the next reset.
- R4: In standard timing, `out_rdy` is 1 exactly when at least one word is stored. `in_rdy` is 0 exactly when DEPTH words are stored.
- R5: In standard timing, a read with `out_rdy`=1 puts the oldest stored word on `dout` after that edge. Without such a read, `dout` holds its value, including for the first word after empty.
- R6: In fall-through timing, a word written into an empty buffer appears on `dout` with `out_rdy`=1 after the second edge following the write, without any read.
- R7: In fall-through timing, a read with `out_rdy`=1 consumes the presented word. If another word is stored, it is presented at the same edge. Otherwise `out_rdy` falls and `dout` holds. Occupancy counts the presented word, and `in_rdy` is 0 when occupancy equals DEPTH.
- R8: Outside start-up, `ae_n` is 0 exactly when occupancy is less than or equal to the empty threshold.
- R9: Outside start-up, `af_n` is 0 exactly when DEPTH minus occupancy is less than or equal to the full threshold.
- R10: A cycle with `ofs_wr`=1 loads `ofs_val` into the empty threshold when `ofs_sel`=0, or into the full threshold when `ofs_sel`=1. The new value takes effect after that edge.
- R11: A write with `in_rdy`=0 is ignored, and a read with `out_rdy`=0 is ignored. Neither changes occupancy, `dout` or the order of stored words.
- R12: An accepted write and an accepted read in the same cycle leave occupancy unchanged and keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fwft_sel | input | 1 | Timing mode sampled during reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Write data |
| in_rdy | output | 1 | Space available (full flag in standard timing, input-ready in fall-through timing) |
| rd_en | input | 1 | Read request |
| dout | output | DW | Read data register |
| out_rdy | output | 1 | Data available (empty flag in standard timing, output-ready in fall-through timing) |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| ofs_wr | input | 1 | Threshold load strobe |
| ofs_sel | input | 1 | Threshold select: 0 = empty threshold, 1 = full threshold |
| ofs_val | input | $clog2(DEPTH+1) | Threshold value |

## Verification
The hazardous overlap is a write landing in the same cycle as a read. In fall-through timing, this is also the cycle in which the output register reloads from storage, so a push and a pop hit the store in one edge. The bench provokes this with a pseudo-random mix of write and read requests at many fill levels in both modes. It also forces the overlap at the full and empty boundaries. Each outcome is judged against an arithmetic queue model of occupancy, the presented word and both threshold comparisons. Every flag and `dout` are compared on every cycle.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_WAKE  = 2'd1,
        ST_RUN   = 2'd2
    } phase_t;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_HELD  = 1'b1
    } ostage_t;

endpackage

// File: rtl/dmf_ctl.sv
module dmf_ctl
    import dmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fwft_sel,
    output logic fwft_q,
    output logic run
);

    phase_t state;
    phase_t state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RESET;
            fwft_q <= fwft_sel;
        end else begin
            state  <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET: state_nxt = ST_WAKE;
            ST_WAKE:  state_nxt = ST_RUN;
            ST_RUN:   state_nxt = ST_RUN;
            default:  state_nxt = ST_RESET;
        endcase
    end

    always_comb begin
        run = (state == ST_RUN);
    end

    // R3: mode is frozen once running
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(fwft_q));

endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   cnt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        rdata = mem[rptr];
    end

    // R11: storage never exceeds its capacity
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R11: a pop never happens on an empty store
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !pop);

endmodule

// File: rtl/dmf_outstage.sv
module dmf_outstage
    import dmf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft,
    input  logic          run,
    input  logic          rd_en,
    input  logic          stored,
    input  logic [DW-1:0] rdata,
    output logic          pop,
    output logic          ovalid,
    output logic [DW-1:0] dout
);

    ostage_t os;
    ostage_t os_nxt;

    always_comb begin
        if (!run || !stored) begin
            pop = 1'b0;
        end else if (fwft) begin
            pop = (os == OS_EMPTY) || rd_en;
        end else begin
            pop = rd_en;
        end
    end

    always_comb begin
        os_nxt = os;
        unique case (os)
            OS_EMPTY: os_nxt = (fwft && pop) ? OS_HELD : OS_EMPTY;
            OS_HELD:  os_nxt = pop ? OS_HELD : (rd_en ? OS_EMPTY : OS_HELD);
            default:  os_nxt = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os   <= OS_EMPTY;
            dout <= '0;
        end else begin
            os <= os_nxt;
            if (pop) begin
                dout <= rdata;
            end
        end
    end

    always_comb begin
        ovalid = (os == OS_HELD);
    end

    // R6: the output register is only ever held in fall-through timing
    p_held_only_fwft_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovalid |-> fwft);

endmodule

// File: rtl/dmf_thresh.sv
module dmf_thresh #(
    parameter int DEPTH   = 16,
    parameter int DEF_OFS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [$clog2(DEPTH+1)-1:0]  occ,
    input  logic                        ofs_wr,
    input  logic                        ofs_sel,
    input  logic [$clog2(DEPTH+1)-1:0]  ofs_val,
    output logic                        ae_n,
    output logic                        af_n
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] ofs_e;
    logic [CW-1:0] ofs_f;
    logic [CW-1:0] free;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_e <= CW'(DEF_OFS);
            ofs_f <= CW'(DEF_OFS);
        end else if (ofs_wr) begin
            if (ofs_sel) begin
                ofs_f <= ofs_val;
            end else begin
                ofs_e <= ofs_val;
            end
        end
    end

    always_comb begin
        free = CW'(DEPTH) - occ;
        ae_n = run && (occ > ofs_e);
        af_n = !run || (free > ofs_f);
    end

    // R8: with nothing stored the almost-empty flag is always asserted
    p_empty_is_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !ae_n);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter int DEF_OFS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fwft_sel,
    input  logic                        wr_en,
    input  logic [DW-1:0]               wdata,
    output logic                        in_rdy,
    input  logic                        rd_en,
    output logic [DW-1:0]               dout,
    output logic                        out_rdy,
    output logic                        ae_n,
    output logic                        af_n,
    input  logic                        ofs_wr,
    input  logic                        ofs_sel,
    input  logic [$clog2(DEPTH+1)-1:0]  ofs_val
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          fwft_q;
    logic          run;
    logic          push;
    logic          pop;
    logic          ovalid;
    logic [DW-1:0] rdata;
    logic [CW-1:0] cnt;
    logic [CW-1:0] occ;

    dmf_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwft_sel (fwft_sel),
        .fwft_q   (fwft_q),
        .run      (run)
    );

    dmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .rdata (rdata),
        .cnt   (cnt)
    );

    dmf_outstage #(.DW(DW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwft   (fwft_q),
        .run    (run),
        .rd_en  (rd_en),
        .stored (cnt != '0),
        .rdata  (rdata),
        .pop    (pop),
        .ovalid (ovalid),
        .dout   (dout)
    );

    dmf_thresh #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .occ     (occ),
        .ofs_wr  (ofs_wr),
        .ofs_sel (ofs_sel),
        .ofs_val (ofs_val),
        .ae_n    (ae_n),
        .af_n    (af_n)
    );

    always_comb begin
        occ     = cnt + CW'(ovalid);
        in_rdy  = run && (occ < CW'(DEPTH));
        push    = wr_en && in_rdy;
        out_rdy = fwft_q ? ovalid : (run && (cnt != '0));
    end

    // R1: reset forces the flag pattern on the following cycle
    p_reset_flags_r1: assert property (@(posedge clk)
        !rst_n |=> (!in_rdy && !out_rdy && !ae_n && af_n));

    // R2: write space is never reported in the cycle right after reset
    p_release_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdy |-> $past(rst_n));

    // R5: standard timing changes dout only on an accepted read
    p_std_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft_q && !(rd_en && out_rdy)) |=> $stable(dout));

    // R7: a presented word stays until it is read
    p_fwft_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft_q && out_rdy && !rd_en) |=> (out_rdy && $stable(dout)));

endmodule

// File: tb/dual_mode_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_mode_fifo_tb_top;

    localparam int D  = 16;
    localparam int DW = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          in_rdy;
    logic          rd_en = 1'b0;
    logic [DW-1:0] dout;
    logic          out_rdy;
    logic          ae_n;
    logic          af_n;
    logic          ofs_wr = 1'b0;
    logic          ofs_sel = 1'b0;
    logic [CW-1:0] ofs_val = '0;

    always #2.5 clk = ~clk;

    dual_mode_fifo #(.DW(DW), .DEPTH(D), .DEF_OFS(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwft_sel (fwft_sel),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .in_rdy   (in_rdy),
        .rd_en    (rd_en),
        .dout     (dout),
        .out_rdy  (out_rdy),
        .ae_n     (ae_n),
        .af_n     (af_n),
        .ofs_wr   (ofs_wr),
        .ofs_sel  (ofs_sel),
        .ofs_val  (ofs_val)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string ph = "-";

    // reference model state
    int q[$];
    bit ov = 0;
    int od = 0;
    int rc = 0;
    bit mode = 0;
    int oe = 8;
    int of = 8;
    int wctr = 1;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t", tag, ph, what, act, exp, $time);
        end
    endtask

    task automatic check();
        bit run;
        int occ;
        int e_in, e_out, e_ae, e_af;
        string t_in, t_out, t_ae, t_af, t_do;
        run  = (rc == 2);
        occ  = q.size() + ov;
        e_in  = (run && occ < D) ? 1 : 0;
        e_out = mode ? ov : ((run && q.size() > 0) ? 1 : 0);
        e_ae  = run ? ((occ > oe) ? 1 : 0) : 0;
        e_af  = run ? ((D - occ > of) ? 1 : 0) : 1;
        if (!rst_n) begin
            t_in = "R1"; t_out = "R1"; t_ae = "R1"; t_af = "R1"; t_do = "R1";
        end else if (!run) begin
            t_in = "R2"; t_out = "R2"; t_ae = "R2"; t_af = "R2"; t_do = "R2";
        end else begin
            t_in  = mode ? "R7" : "R4";
            t_out = mode ? "R6,R3" : "R4,R3";
            t_ae  = "R8,R10";
            t_af  = "R9,R10";
            t_do  = mode ? "R7" : "R5";
        end
        cmp(t_in,  "in_rdy",  int'(in_rdy),  e_in);
        cmp(t_out, "out_rdy", int'(out_rdy), e_out);
        cmp(t_ae,  "ae_n",    int'(ae_n),    e_ae);
        cmp(t_af,  "af_n",    int'(af_n),    e_af);
        cmp(t_do,  "dout",    int'(dout),    od);
    endtask

    task automatic cyc(input bit w, input bit r, input bit ow = 0, input bit os = 0, input int ovv = 0);
        bit run;
        bit acc;
        int occ;
        wr_en   = w;
        rd_en   = r;
        wdata   = DW'(wctr);
        ofs_wr  = ow;
        ofs_sel = os;
        ofs_val = CW'(ovv);
        @(posedge clk);
        if (!rst_n) begin
            rc = 0; mode = fwft_sel; q.delete(); ov = 0; od = 0; oe = 8; of = 8;
        end else begin
            run = (rc == 2);
            occ = q.size() + ov;
            acc = w && run && (occ < D);
            if (mode) begin
                if (run && q.size() > 0 && (!ov || r)) begin
                    od = q.pop_front();
                    ov = 1;
                end else if (r && ov) begin
                    ov = 0;
                end
            end else if (r && run && q.size() > 0) begin
                od = q.pop_front();
            end
            if (acc) q.push_back(wctr & 255);
            if (w) wctr++;
            if (ow) begin
                if (os) of = ovv; else oe = ovv;
            end
            if (rc < 2) rc++;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; ofs_wr = 1'b0;
        check();
    endtask

    task automatic do_reset(input bit m);
        ph = "R1";
        rst_n = 1'b0;
        fwft_sel = m;
        cyc(0, 0);
        cyc(0, 0);
        rst_n = 1'b1;
        fwft_sel = ~m;   // R3: value outside reset must not matter
        ph = "R2";
        cyc(0, 0);
        cyc(0, 0);
    endtask

    task automatic run_mode(input bit m);
        int vals[6] = '{0, 1, 7, 8, 15, 16};
        logic [15:0] lfsr;
        do_reset(m);
        // R3/R6: single word after empty
        ph = "R6";
        cyc(1, 0);
        cyc(0, 0);
        cyc(0, 0);
        cyc(0, 1);
        cyc(0, 1);
        for (int k = 0; k < 6; k++) begin
            ph = "R10";
            cyc(0, 0, 1, 0, vals[k]);
            cyc(0, 0, 1, 1, vals[5 - k]);
            ph = "R8";
            for (int i = 0; i < D + 3; i++) begin
                if (i >= D) ph = "R11";
                cyc(1, 0);
            end
            // R12: overlap at full boundary
            ph = "R12";
            cyc(1, 1);
            cyc(1, 0);
            ph = "R9";
            for (int i = 0; i < D + 3; i++) begin
                if (i >= D + 1) ph = "R11";
                cyc(0, 1);
            end
            // R12: overlap at empty boundary
            ph = "R12";
            cyc(1, 1);
            cyc(0, 1);
            cyc(0, 1);
            cyc(0, 1);
        end
        ph = "R12";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[3] | (i > 200 && lfsr[7]));
        end
        // reset mid-traffic returns to defaults (R1)
        do_reset(m);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        run_mode(1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R2) actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule